// File: doc/BRIEF.md
# Predicate and Branch Target Unit

This block decides, for each issued instruction, whether that instruction is allowed to take effect, and computes the target address when the instruction is a branch. A 3-bit selector names one of five condition registers, or an unconditional code. The selected register is tested for zero. The test can be inverted. The result is a generic execute-enable that any functional unit can use to gate its write-back.

Branches come in two forms. A relative branch carries a signed 21-bit word offset. The offset is sign-extended, scaled by four and added to the current fetch-packet address. An absolute branch takes a full 32-bit target from a register value that the register file supplies. The absolute form is legal only when it is issued on the second-side shift unit. On the first side it raises an illegal-operation flag, and neither execution nor the branch takes place.

All outputs are registered and appear one clock after the issue cycle. The register file, flushing, delay slots and fetch stay outside the block.

Top module: `pred_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are zero in the following cycle.
- R2: Selector codes 1 to 5 choose B0, B1, B2, A1 and A2 in that order. With `pred_inv` low, execution is enabled when the chosen register is non-zero.
- R3: With `pred_inv` high and a selector from 1 to 5, execution is enabled exactly when the chosen register equals zero.
- R4: Selector code 0 means unconditional. It enables execution whatever the register values and whatever `pred_inv` is.
- R5: Selector codes 6 and 7 are reserved. An instruction that uses one is not executed and raises `illegal_op`.
- R6: Outputs reflect the instruction presented one clock earlier. A cycle without `issue_vld` gives `exec_en`, `br_taken` and `illegal_op` all low.
- R7: An executed relative branch (`br_req`=1, `br_abs`=0) asserts `br_taken`. Its `br_target` is `pc_fetch` plus the sign-extended `br_off` shifted left by 2, taken modulo 2^32.
- R8: An executed absolute branch (`br_abs`=1) issued with `unit_s2`=1 asserts `br_taken`, and `br_target` equals `reg_tgt`.
- R9: An absolute branch with `unit_s2`=0 raises `illegal_op` and leaves `br_taken` and `exec_en` low, whatever the predicate.
- R10: When the predicate is false, `exec_en` and `br_taken` stay low.
- R11: An executed instruction with `br_req`=0 asserts `exec_en` with `br_taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| pred_sel | input | 3 | Condition selector: 0 unconditional, 1..5 registers, 6..7 reserved |
| pred_inv | input | 1 | Invert the zero test |
| creg_b0 | input | 32 | Value of condition register B0 |
| creg_b1 | input | 32 | Value of condition register B1 |
| creg_b2 | input | 32 | Value of condition register B2 |
| creg_a1 | input | 32 | Value of condition register A1 |
| creg_a2 | input | 32 | Value of condition register A2 |
| br_req | input | 1 | The instruction is a branch |
| br_abs | input | 1 | Branch takes its target from a register |
| unit_s2 | input | 1 | Issued on the second-side shift unit |
| br_off | input | 21 | Signed relative offset in instruction words |
| pc_fetch | input | 32 | Current fetch-packet address |
| reg_tgt | input | 32 | Register value used as an absolute target |
| exec_en | output | 1 | Instruction may execute |
| br_taken | output | 1 | Branch is taken |
| br_target | output | 32 | Branch target address |
| illegal_op | output | 1 | Reserved selector or absolute branch on side 1 |

## Verification
The bench builds the block with the default widths: 32-bit data and addresses and a 21-bit offset. With these widths the offset extremes of plus 2^20-1 and minus 2^20 words can be reached directly. So can a fetch address near the top of the space, which shows the modulo-2^32 wrap. Every selector code is driven against register values that are zero and non-zero, with both polarities. This covers the reserved codes and the case where the unconditional code ignores inversion. The absolute form is tried on both sides under true and false predicates.

// File: rtl/pbu_pkg.sv
package pbu_pkg;

    typedef enum logic [2:0] {
        SEL_ALWAYS = 3'd0,
        SEL_B0     = 3'd1,
        SEL_B1     = 3'd2,
        SEL_B2     = 3'd3,
        SEL_A1     = 3'd4,
        SEL_A2     = 3'd5,
        SEL_RSV6   = 3'd6,
        SEL_RSV7   = 3'd7
    } pred_sel_e;

    localparam int NUM_CREG = 5;
    localparam int SEL_W    = 3;

    typedef struct packed {
        logic exec;
        logic taken;
        logic illegal;
    } pbu_flags_t;

    // true when the code names one of the condition registers
    function automatic logic sel_is_reg(input logic [SEL_W-1:0] s);
        return (s >= SEL_B0) && (s <= SEL_A2);
    endfunction

endpackage

// File: rtl/pbu_cond_eval.sv
module pbu_cond_eval
    import pbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [SEL_W-1:0]                 sel,
    input  logic                             inv,
    input  logic [NUM_CREG-1:0][DATA_W-1:0]  cregs,
    output logic                             pass,
    output logic                             bad_sel
);

    logic [NUM_CREG-1:0] nonzero;
    logic [NUM_CREG-1:0] hit;

    for (genvar i = 0; i < NUM_CREG; i++) begin : g_slot
        assign nonzero[i] = |cregs[i];
        assign hit[i]     = (sel == SEL_W'(i + 1)) && nonzero[i];
    end

    always_comb begin
        bad_sel = !sel_is_reg(sel) && (sel != SEL_ALWAYS);
        if (sel == SEL_ALWAYS)
            pass = 1'b1;
        else if (bad_sel)
            pass = 1'b0;
        else
            pass = inv ? !(|hit) : (|hit);
    end

endmodule

// File: rtl/pbu_tgt_calc.sv
module pbu_tgt_calc #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 21
) (
    input  logic              use_reg,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  off,
    input  logic [ADDR_W-1:0] reg_val,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] rel_tgt;

    assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    assign rel_tgt = pc + (off_ext << 2);
    assign target  = use_reg ? reg_val : rel_tgt;

endmodule

// File: rtl/pred_branch_unit.sv
module pred_branch_unit
    import pbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_vld,
    input  logic [2:0]        pred_sel,
    input  logic              pred_inv,
    input  logic [DATA_W-1:0] creg_b0,
    input  logic [DATA_W-1:0] creg_b1,
    input  logic [DATA_W-1:0] creg_b2,
    input  logic [DATA_W-1:0] creg_a1,
    input  logic [DATA_W-1:0] creg_a2,
    input  logic              br_req,
    input  logic              br_abs,
    input  logic              unit_s2,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [ADDR_W-1:0] pc_fetch,
    input  logic [ADDR_W-1:0] reg_tgt,
    output logic              exec_en,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target,
    output logic              illegal_op
);

    logic [NUM_CREG-1:0][DATA_W-1:0] cregs;
    logic                            pass;
    logic                            bad_sel;
    logic                            bad_side;
    logic [ADDR_W-1:0]               tgt_nxt;
    pbu_flags_t                      flg_nxt;
    pbu_flags_t                      flg_q;

    assign cregs = {creg_a2, creg_a1, creg_b2, creg_b1, creg_b0};

    pbu_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .sel     (pred_sel),
        .inv     (pred_inv),
        .cregs   (cregs),
        .pass    (pass),
        .bad_sel (bad_sel)
    );

    pbu_tgt_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
        .use_reg (br_abs),
        .pc      (pc_fetch),
        .off     (br_off),
        .reg_val (reg_tgt),
        .target  (tgt_nxt)
    );

    assign bad_side = br_req && br_abs && !unit_s2;

    always_comb begin
        flg_nxt.illegal = issue_vld && (bad_sel || bad_side);
        flg_nxt.exec    = issue_vld && pass && !bad_side;
        flg_nxt.taken   = flg_nxt.exec && br_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q     <= '0;
            br_target <= '0;
        end else begin
            flg_q     <= flg_nxt;
            br_target <= tgt_nxt;
        end
    end

    assign exec_en    = flg_q.exec;
    assign br_taken   = flg_q.taken;
    assign illegal_op = flg_q.illegal;

    assert_taken_implies_exec_R11: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> exec_en);

    assert_side1_abs_blocked_R9: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && br_req && br_abs && !unit_s2) |=> (illegal_op && !br_taken && !exec_en));

    assert_uncond_executes_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && pred_sel == 3'd0 && !(br_req && br_abs && !unit_s2)) |=> exec_en);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !issue_vld |=> (!exec_en && !br_taken && !illegal_op));

    assert_reserved_sel_R5: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && pred_sel[2:1] == 2'b11) |=> (illegal_op && !exec_en));

    assert_abs_target_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && br_req && br_abs && unit_s2) |=> (br_target == $past(reg_tgt)));

endmodule

// File: tb/tb_pred_branch_unit.sv
module tb_pred_branch_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue_vld;
    logic [2:0]  pred_sel;
    logic        pred_inv;
    logic [31:0] creg_b0, creg_b1, creg_b2, creg_a1, creg_a2;
    logic        br_req, br_abs, unit_s2;
    logic [20:0] br_off;
    logic [31:0] pc_fetch, reg_tgt;
    logic        exec_en, br_taken, illegal_op;
    logic [31:0] br_target;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pred_branch_unit dut (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .pred_sel(pred_sel),
        .pred_inv(pred_inv), .creg_b0(creg_b0), .creg_b1(creg_b1),
        .creg_b2(creg_b2), .creg_a1(creg_a1), .creg_a2(creg_a2),
        .br_req(br_req), .br_abs(br_abs), .unit_s2(unit_s2), .br_off(br_off),
        .pc_fetch(pc_fetch), .reg_tgt(reg_tgt), .exec_en(exec_en),
        .br_taken(br_taken), .br_target(br_target), .illegal_op(illegal_op)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic e, input logic t, input logic i);
        chk({req, " exec_en"}, {31'd0, exec_en}, {31'd0, e});
        chk({req, " br_taken"}, {31'd0, br_taken}, {31'd0, t});
        chk({req, " illegal_op"}, {31'd0, illegal_op}, {31'd0, i});
    endtask

    // drive at a falling edge, outputs register at the next rising edge,
    // sample at the falling edge after it
    task automatic issue(input logic [2:0] s, input logic inv, input logic br,
                         input logic ab, input logic s2, input logic [20:0] off,
                         input logic [31:0] pc, input logic [31:0] rt);
        issue_vld = 1'b1; pred_sel = s; pred_inv = inv; br_req = br;
        br_abs = ab; unit_s2 = s2; br_off = off; pc_fetch = pc; reg_tgt = rt;
        @(negedge clk);
        issue_vld = 1'b0;
    endtask

    task automatic t_reset_R1();
        rst = 1'b1;
        issue(3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 21'd3, 32'h100, 32'h0);
        chk_flags("R1", 1'b0, 1'b0, 1'b0);
        chk("R1 br_target", br_target, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_select_R2();
        creg_b0 = 0; creg_b1 = 0; creg_b2 = 0; creg_a1 = 0; creg_a2 = 0;
        for (int k = 1; k <= 5; k++) begin
            issue(3'(k), 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
            chk_flags("R2 zero reg", 1'b0, 1'b0, 1'b0);
        end
        creg_b0 = 32'h1; issue(3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R2 B0", 1'b1, 1'b0, 1'b0);
        issue(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R2 B1 stays zero", 1'b0, 1'b0, 1'b0);
        creg_b0 = 0; creg_b1 = 32'h8000_0000;
        issue(3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R2 B1", 1'b1, 1'b0, 1'b0);
        creg_b1 = 0; creg_b2 = 32'h10;
        issue(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R2 B2", 1'b1, 1'b0, 1'b0);
        creg_b2 = 0; creg_a1 = 32'h2;
        issue(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R2 A1", 1'b1, 1'b0, 1'b0);
        issue(3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R2 A2 stays zero", 1'b0, 1'b0, 1'b0);
        creg_a1 = 0; creg_a2 = 32'h0001_0000;
        issue(3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R2 A2", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_invert_R3();
        creg_b0 = 0; creg_b1 = 0; creg_b2 = 5; creg_a1 = 0; creg_a2 = 0;
        issue(3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R3 nonzero inverted", 1'b0, 1'b0, 1'b0);
        issue(3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R3 zero inverted", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_uncond_R4();
        creg_b0 = 0; creg_b1 = 0; creg_b2 = 0; creg_a1 = 0; creg_a2 = 0;
        issue(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R4 plain", 1'b1, 1'b0, 1'b0);
        creg_b0 = 32'hFFFF_FFFF;
        issue(3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R4 inverted", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_reserved_R5();
        creg_b0 = 1; creg_b1 = 1; creg_b2 = 1; creg_a1 = 1; creg_a2 = 1;
        issue(3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 21'd1, 32'h0, 32'h0);
        chk_flags("R5 code6", 1'b0, 1'b0, 1'b1);
        issue(3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R5 code7", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_idle_R6();
        issue(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 21'd1, 32'h0, 32'h0);
        chk_flags("R6 issued", 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk_flags("R6 idle", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_relative_R7();
        issue(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 21'h1FFFFF, 32'h0000_1000, 32'hDEAD_BEEF);
        chk_flags("R7 back1", 1'b1, 1'b1, 1'b0);
        chk("R7 back1 target", br_target, 32'h0000_0FFC);
        issue(3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 21'h0FFFFF, 32'h0000_1000, 32'h0);
        chk("R7 max forward", br_target, 32'h0040_0FFC);
        issue(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 21'h100000, 32'h0000_1000, 32'h0);
        chk("R7 max backward", br_target, 32'hFFC0_1000);
        issue(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 21'd8, 32'hFFFF_FFF0, 32'h0);
        chk("R7 wrap", br_target, 32'h0000_0010);
    endtask

    task automatic t_abs_side2_R8();
        creg_a1 = 32'h3;
        issue(3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 21'd5, 32'h0000_2000, 32'h8765_4321);
        chk_flags("R8", 1'b1, 1'b1, 1'b0);
        chk("R8 target", br_target, 32'h8765_4321);
    endtask

    task automatic t_abs_side1_R9();
        issue(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 21'd0, 32'h0, 32'h1234_5678);
        chk_flags("R9 true pred", 1'b0, 1'b0, 1'b1);
        creg_b2 = 0;
        issue(3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 21'd0, 32'h0, 32'h1234_5678);
        chk_flags("R9 false pred", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_false_pred_R10();
        creg_b1 = 0;
        issue(3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 21'd4, 32'h100, 32'h0);
        chk_flags("R10 rel", 1'b0, 1'b0, 1'b0);
        creg_b1 = 7;
        issue(3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 21'd0, 32'h0, 32'h55);
        chk_flags("R10 abs inverted", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_nonbranch_R11();
        creg_a2 = 9;
        issue(3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 21'd0, 32'h0, 32'h0);
        chk_flags("R11", 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        rst = 1'b1; issue_vld = 1'b0; pred_sel = 0; pred_inv = 0;
        creg_b0 = 0; creg_b1 = 0; creg_b2 = 0; creg_a1 = 0; creg_a2 = 0;
        br_req = 0; br_abs = 0; unit_s2 = 0; br_off = 0; pc_fetch = 0; reg_tgt = 0;
        repeat (3) @(negedge clk);
        t_reset_R1();
        t_select_R2();
        t_invert_R3();
        t_uncond_R4();
        t_reserved_R5();
        t_idle_R6();
        t_relative_R7();
        t_abs_side2_R8();
        t_abs_side1_R9();
        t_false_pred_R10();
        t_nonbranch_R11();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule